// File: doc/BRIEF.md
# Cache Maintenance Command Controller

This block is the software-facing front end for maintenance operations on a shared last-level cache. Software sees a small map of 64-bit registers on a simple read/write bus. It first polls a ready flag until the flag reads 1. It then writes the tag and then the set of the target cache block. Finally it writes a command number, and that write starts the operation.

Each accepted command becomes exactly one request to the cache. The request carries an op code, a tag and a set, and travels over a valid/ready handshake. Once the cache accepts the request, the block waits for a one-cycle done pulse. The ready flag is 0 from the cycle after acceptance until that pulse arrives, so only one operation is ever in flight.

The cache side follows these back-pressure rules. The block keeps `cmo_req_valid` high, with op, tag and set stable, until it samples `cmo_req_ready` high on a clock edge. It never withdraws a request. It ignores `cmo_done` unless it is waiting for completion. The clean command is carried out as a full flush.

Top module: `cmo_ctrl`

## Requirements
- R1: After reset the ready flag (bit 0 of offset 0x180) reads 1, the tag and set registers read 0, and `cmo_req_valid` is 0.
- R2: The tag register at 0x100 and the set register at 0x108 are writable, and each reads back the low TAG_W or SET_W bits of the value written, zero-extended to 64 bits. The command register at 0x200 and unmapped offsets read 0.
- R3: The nine legacy registers (way at 0x110, data at 0x118 through 0x150 in steps of 8) store full 64-bit writes and read them back. They never affect a request.
- R4: Writing 16 to 0x200 while the flag is 1 issues one request with `cmo_req_op` = 2'b01 (invalidate), carrying the current tag and set register values.
- R5: Writing 18 to 0x200 while the flag is 1 issues one request with `cmo_req_op` = 2'b10 (flush), carrying the current tag and set.
- R6: Writing 17 (clean) produces a request identical to the one for command 18: op 2'b10 with the same tag and set.
- R7: A write to 0x200 of any value other than 16, 17 or 18 is ignored. The flag stays 1 and no request is issued.
- R8: After a valid command write, the flag reads 0 starting the next cycle. It stays 0 until the cycle after the cache's `cmo_done` pulse, and then reads 1 again.
- R9: A command written while the flag is 0 is dropped. The tag and set are latched at acceptance, so later register writes do not change the request in flight.
- R10: `cmo_req_valid` is held, with op, tag and set stable, until `cmo_req_ready` is seen high. At most one request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | ADDR_W (12) | Register byte offset |
| bus_wdata | input | DATA_W (64) | Write data |
| bus_rdata | output | DATA_W (64) | Read data for `bus_addr`, combinational |
| cmo_req_valid | output | 1 | Maintenance request valid |
| cmo_req_ready | input | 1 | Cache accepts the request |
| cmo_req_op | output | 2 | 2'b01 invalidate, 2'b10 flush |
| cmo_req_tag | output | TAG_W (32) | Tag of the target block |
| cmo_req_set | output | SET_W (12) | Set of the target block |
| cmo_done | input | 1 | One-cycle completion pulse from the cache |

## Verification
The assertions check four things on every cycle. A pending request stays stable while it waits for ready. Only invalidate or flush op codes ever appear. An accepted command clears the flag on the next cycle, while an illegal code leaves it set. The flag rises only after a done pulse. The bench scenarios cover what a per-cycle property cannot express: that the tag and set the cache receives are the values software wrote before the command, that clean and flush produce matching requests, that a command dropped while busy never appears, and that the legacy registers keep their data without influencing any request.

// File: rtl/cmo_pkg.sv
package cmo_pkg;
  typedef enum logic [1:0] {
    CMO_OP_NONE  = 2'b00,
    CMO_OP_INV   = 2'b01,
    CMO_OP_FLUSH = 2'b10
  } cmo_op_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'b00,
    SEQ_ISSUE = 2'b01,
    SEQ_WAIT  = 2'b10
  } seq_state_e;

  localparam int CODE_INV   = 16;
  localparam int CODE_CLEAN = 17;
  localparam int CODE_FLUSH = 18;

  localparam int OFF_TAG    = 'h100;
  localparam int OFF_SET    = 'h108;
  localparam int OFF_LEGACY = 'h110;
  localparam int OFF_FLAG   = 'h180;
  localparam int OFF_CMD    = 'h200;
endpackage

// File: rtl/cmo_regfile.sv
module cmo_regfile
  import cmo_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int DATA_W        = 64,
  parameter int TAG_W         = 32,
  parameter int SET_W         = 12,
  parameter int NUM_DATA_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              flag_in,
  output logic [DATA_W-1:0] rdata,
  output logic [TAG_W-1:0]  tag_q,
  output logic [SET_W-1:0]  set_q,
  output logic              cmd_wr
);
  localparam int NUM_LEG = NUM_DATA_REGS + 1;

  logic [DATA_W-1:0] leg_q [NUM_LEG];

  assign cmd_wr = wen && (addr == ADDR_W'(OFF_CMD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      set_q <= '0;
    end else if (wen) begin
      if (addr == ADDR_W'(OFF_TAG)) tag_q <= wdata[TAG_W-1:0];
      if (addr == ADDR_W'(OFF_SET)) set_q <= wdata[SET_W-1:0];
    end
  end

  for (genvar k = 0; k < NUM_LEG; k++) begin : g_leg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) leg_q[k] <= '0;
      else if (wen && addr == ADDR_W'(OFF_LEGACY + 8 * k)) leg_q[k] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFF_TAG))  rdata = DATA_W'(tag_q);
    if (addr == ADDR_W'(OFF_SET))  rdata = DATA_W'(set_q);
    if (addr == ADDR_W'(OFF_FLAG)) rdata = DATA_W'(flag_in);
    for (int k = 0; k < NUM_LEG; k++) begin
      if (addr == ADDR_W'(OFF_LEGACY + 8 * k)) rdata = leg_q[k];
    end
  end
endmodule

// File: rtl/cmo_cmd_decode.sv
module cmo_cmd_decode
  import cmo_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] cmd_val,
  output logic              legal,
  output cmo_op_e           op
);
  always_comb begin
    legal = 1'b1;
    op    = CMO_OP_NONE;
    case (cmd_val)
      DATA_W'(CODE_INV):   op = CMO_OP_INV;
      DATA_W'(CODE_CLEAN): op = CMO_OP_FLUSH; // clean is served as a full flush
      DATA_W'(CODE_FLUSH): op = CMO_OP_FLUSH;
      default:             legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmo_req_seq.sv
module cmo_req_seq
  import cmo_pkg::*;
#(
  parameter int TAG_W = 32,
  parameter int SET_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             legal,
  input  cmo_op_e          op_in,
  input  logic [TAG_W-1:0] tag_in,
  input  logic [SET_W-1:0] set_in,
  output logic             idle,
  output logic             req_valid,
  input  logic             req_ready,
  output cmo_op_e          req_op,
  output logic [TAG_W-1:0] req_tag,
  output logic [SET_W-1:0] req_set,
  input  logic             done
);
  seq_state_e state_q;

  assign idle      = (state_q == SEQ_IDLE);
  assign req_valid = (state_q == SEQ_ISSUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      req_op  <= CMO_OP_NONE;
      req_tag <= '0;
      req_set <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (start && legal) begin
          req_op  <= op_in;
          req_tag <= tag_in;
          req_set <= set_in;
          state_q <= SEQ_ISSUE;
        end
        SEQ_ISSUE: if (req_ready) state_q <= SEQ_WAIT;
        SEQ_WAIT:  if (done) state_q <= SEQ_IDLE;
        default:   state_q <= SEQ_IDLE;
      endcase
    end
  end

  // R10: pending request held stable until accepted
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_op) && $stable(req_tag) && $stable(req_set));

  // R4, R5: only invalidate or flush reach the cache
  p_op_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_op == CMO_OP_INV || req_op == CMO_OP_FLUSH));

  // R8: flag returns only after a completion pulse
  p_flag_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> $past(done));
endmodule

// File: rtl/cmo_ctrl.sv
module cmo_ctrl
  import cmo_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int DATA_W        = 64,
  parameter int TAG_W         = 32,
  parameter int SET_W         = 12,
  parameter int NUM_DATA_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cmo_req_valid,
  input  logic              cmo_req_ready,
  output logic [1:0]        cmo_req_op,
  output logic [TAG_W-1:0]  cmo_req_tag,
  output logic [SET_W-1:0]  cmo_req_set,
  input  logic              cmo_done
);
  logic             flag;
  logic             cmd_wr;
  logic             cmd_legal;
  cmo_op_e          cmd_op;
  cmo_op_e          req_op;
  logic [TAG_W-1:0] tag_q;
  logic [SET_W-1:0] set_q;

  cmo_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .SET_W(SET_W),
    .NUM_DATA_REGS(NUM_DATA_REGS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(bus_wen), .addr(bus_addr), .wdata(bus_wdata),
    .flag_in(flag), .rdata(bus_rdata), .tag_q(tag_q), .set_q(set_q), .cmd_wr(cmd_wr)
  );

  cmo_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .cmd_val(bus_wdata), .legal(cmd_legal), .op(cmd_op)
  );

  cmo_req_seq #(.TAG_W(TAG_W), .SET_W(SET_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(cmd_wr), .legal(cmd_legal), .op_in(cmd_op),
    .tag_in(tag_q), .set_in(set_q), .idle(flag), .req_valid(cmo_req_valid),
    .req_ready(cmo_req_ready), .req_op(req_op), .req_tag(cmo_req_tag),
    .req_set(cmo_req_set), .done(cmo_done)
  );

  assign cmo_req_op = req_op;

  // R8: an accepted command drops the flag on the next cycle
  p_accept_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wen && bus_addr == ADDR_W'(OFF_CMD) && flag &&
    (bus_wdata == DATA_W'(CODE_INV) || bus_wdata == DATA_W'(CODE_CLEAN) ||
     bus_wdata == DATA_W'(CODE_FLUSH)) |=> !flag);

  // R7: an unknown code leaves the block ready with no request
  p_illegal_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wen && bus_addr == ADDR_W'(OFF_CMD) && flag &&
    bus_wdata != DATA_W'(CODE_INV) && bus_wdata != DATA_W'(CODE_CLEAN) &&
    bus_wdata != DATA_W'(CODE_FLUSH) |=> flag && !cmo_req_valid);
endmodule

// File: tb/cmo_ctrl_tb_top.sv
module cmo_ctrl_tb_top;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 64;
  localparam int TAG_W  = 32;
  localparam int SET_W  = 12;

  typedef struct packed {
    logic [1:0]       op;
    logic [TAG_W-1:0] tag;
    logic [SET_W-1:0] set;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wen = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              cmo_req_valid;
  logic              cmo_req_ready = 1'b0;
  logic [1:0]        cmo_req_op;
  logic [TAG_W-1:0]  cmo_req_tag;
  logic [SET_W-1:0]  cmo_req_set;
  logic              cmo_done = 1'b0;

  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;
  exp_t exp_q[$];
  int   ready_delay = 0;
  int   done_delay = 1;
  int   rdy_cnt = 0;
  int   done_cnt = 0;
  bit   hs_pending = 0;

  always #10 clk = ~clk; // 50 MHz

  cmo_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmo_req_valid(cmo_req_valid),
    .cmo_req_ready(cmo_req_ready), .cmo_req_op(cmo_req_op), .cmo_req_tag(cmo_req_tag),
    .cmo_req_set(cmo_req_set), .cmo_done(cmo_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // driver: program the block and record the request it must produce
  task automatic issue(input logic [TAG_W-1:0] t, input logic [SET_W-1:0] s,
                       input int code, input logic [1:0] op);
    exp_t e;
    bus_write(12'h100, 64'(t));
    bus_write(12'h108, 64'(s));
    e.op = op; e.tag = t; e.set = s;
    exp_q.push_back(e);
    bus_write(12'h200, 64'(code));
  endtask

  task automatic wait_idle(input string req);
    logic [DATA_W-1:0] v;
    bit seen = 0;
    for (int i = 0; i < 300 && !seen; i++) begin
      bus_read(12'h180, v);
      if (v == 64'd1) seen = 1;
      else @(negedge clk);
    end
    chk(seen, req, "flag never returned to 1", 64'(seen), 64'd1);
  endtask

  // monitor: models the cache and compares each request with the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      cmo_done = 1'b0;
      if (hs_pending) begin
        hs_pending = 0; cmo_req_ready = 1'b0; done_cnt = done_delay;
      end
      if (done_cnt > 0) begin
        done_cnt--;
        if (done_cnt == 0) cmo_done = 1'b1;
      end else if (cmo_req_valid && !cmo_req_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R9", "request with no accepted command", 64'(cmo_req_op), 64'd0);
        end else begin
          chk(cmo_req_op == exp_q[0].op, "R10", "request op", 64'(cmo_req_op), 64'(exp_q[0].op));
          chk(cmo_req_tag == exp_q[0].tag, "R10", "request tag", 64'(cmo_req_tag), 64'(exp_q[0].tag));
          chk(cmo_req_set == exp_q[0].set, "R10", "request set", 64'(cmo_req_set), 64'(exp_q[0].set));
        end
        if (rdy_cnt >= ready_delay) begin
          cmo_req_ready = 1'b1; hs_pending = 1; rdy_cnt = 0;
          if (exp_q.size() > 0) void'(exp_q.pop_front());
        end else rdy_cnt++;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cmo_req_valid == 1'b0, "R1", "valid during reset", 64'(cmo_req_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(12'h180, v); chk(v == 64'd1, "R1", "flag after reset", v, 64'd1);
    bus_read(12'h100, v); chk(v == 64'd0, "R1", "tag after reset", v, 64'd0);
    bus_read(12'h108, v); chk(v == 64'd0, "R1", "set after reset", v, 64'd0);
    chk(cmo_req_valid == 1'b0, "R1", "valid after reset", 64'(cmo_req_valid), 64'd0);

    // R2: read/write with truncation to field width
    bus_write(12'h100, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_write(12'h108, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_read(12'h100, v); chk(v == 64'h0000_0000_FFFF_FFFF, "R2", "tag readback", v, 64'h0000_0000_FFFF_FFFF);
    bus_read(12'h108, v); chk(v == 64'h0000_0000_0000_0FFF, "R2", "set readback", v, 64'h0000_0000_0000_0FFF);
    bus_read(12'h200, v); chk(v == 64'd0, "R2", "command reads zero", v, 64'd0);
    bus_read(12'h0F8, v); chk(v == 64'd0, "R2", "unmapped reads zero", v, 64'd0);

    // R3: legacy registers hold data
    for (int k = 0; k < 9; k++) bus_write(12'(12'h110 + 8 * k), 64'hA5A5_0000_0000_0000 | 64'(k * 3 + 1));
    for (int k = 0; k < 9; k++) begin
      bus_read(12'(12'h110 + 8 * k), v);
      chk(v == (64'hA5A5_0000_0000_0000 | 64'(k * 3 + 1)), "R3", "legacy readback", v,
          64'hA5A5_0000_0000_0000 | 64'(k * 3 + 1));
    end

    // R4: invalidate; R8: flag drops the cycle after the command
    ready_delay = 0; done_delay = 1;
    issue(32'h1234_5678, 12'h0AB, 16, 2'b01);
    bus_read(12'h180, v); chk(v == 64'd0, "R8", "flag after command", v, 64'd0);
    wait_idle("R4");

    // R5: flush, R6: clean behaves as flush
    issue(32'hDEAD_BEEF, 12'h3C1, 18, 2'b10);
    wait_idle("R5");
    issue(32'hDEAD_BEEF, 12'h3C1, 17, 2'b10);
    wait_idle("R6");

    // R7: unknown codes ignored
    bus_write(12'h200, 64'd0);
    bus_read(12'h180, v); chk(v == 64'd1, "R7", "flag after code 0", v, 64'd1);
    bus_write(12'h200, 64'd19);
    bus_read(12'h180, v); chk(v == 64'd1, "R7", "flag after code 19", v, 64'd1);
    bus_write(12'h200, 64'd15);
    bus_write(12'h200, 64'h1_0000_0010);
    repeat (4) @(negedge clk);
    chk(cmo_req_valid == 1'b0, "R7", "no request from unknown code", 64'(cmo_req_valid), 64'd0);
    bus_read(12'h180, v); chk(v == 64'd1, "R7", "flag still ready", v, 64'd1);

    // R8: flag held low through a slow completion
    ready_delay = 1; done_delay = 14;
    issue(32'h0000_00C3, 12'h001, 18, 2'b10);
    for (int i = 0; i < 10; i++) begin
      bus_read(12'h180, v); chk(v == 64'd0, "R8", "flag while busy", v, 64'd0);
      @(negedge clk);
    end
    wait_idle("R8");

    // R9 and R10: long ready delay, command dropped while busy, tag latched
    ready_delay = 8; done_delay = 2;
    issue(32'h0BAD_F00D, 12'h155, 18, 2'b10);
    bus_write(12'h100, 64'h0000_0000_7777_7777);
    bus_write(12'h200, 64'd16);
    bus_read(12'h180, v); chk(v == 64'd0, "R9", "flag busy after dropped command", v, 64'd0);
    wait_idle("R9");
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "scoreboard drained", 64'(exp_q.size()), 64'd0);
    bus_read(12'h100, v); chk(v == 64'h7777_7777, "R9", "tag holds later write", v, 64'h7777_7777);

    // R3: a request after legacy writes uses only tag and set
    ready_delay = 2; done_delay = 1;
    bus_write(12'h110, 64'hFFFF_FFFF_FFFF_FFFF);
    issue(32'h0000_1111, 12'h222, 16, 2'b01);
    wait_idle("R3");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R10", "all requests seen", 64'(exp_q.size()), 64'd0);
    chk(cmo_req_valid == 1'b0, "R10", "no request left", 64'(cmo_req_valid), 64'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule